// File: doc/BRIEF.md
# Hierarchical Single-Vector Interrupt Controller

This block gathers interrupt events from six peripheral modules, M0 to M5, each with up to 16 sources. It raises one request line to a processor that always jumps to a single software-programmable vector. Each source event sets a sticky flag whether or not that source is enabled. Software clears a flag by writing 1 to its bit. A flag reaches the request line only when three enables agree: its own source enable, its module enable and the global enable.

Software finds the cause in two steps. A top-level identity register has one bit per module, and that bit is set while the module has an enabled, pending source. Modules M1, M4 and M5 also have a 16-bit read-only identity register that shows which enabled sources inside the module are pending. Deciding which cause to serve first is left to software.

When a module's enabled pending state falls, its contribution to the request stays high for a short time. Modules with asynchronous sources hold it for one extra cycle. Modules with synchronous sources hold it for two. All register access goes through a plain write strobe and a combinational read port. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `intc_hier`

## Requirements
- R1: Out of reset, the vector, all enables and all flags read 0, every identity register reads 0 and `irq_o` is low.
- R2: The rising clock edge that samples event bit `m*16+s` set sets flag `s` of module `m`, whatever the three enables hold. With the enables off, `irq_o` stays low.
- R3: Writing a word to the flag register of module `m` (address 0x04+m) clears every flag bit written as 1. Bits written as 0 keep their value.
- R4: When an event and a clear hit the same flag bit in the same cycle, the flag ends up set.
- R5: `irq_o` goes high in the cycle after an event edge when the source enable (address 0x0A+m), the module enable (address 0x01, bit m) and the global enable (address 0x00, bit 0) are all set.
- R6: Bit m of the top identity register (address 0x03) equals the OR over the module's sources of (flag AND source enable), gated by module enable m. The global enable does not gate it.
- R7: The module identity registers at addresses 0x11, 0x14 and 0x15 read (flag AND source enable) for M1, M4 and M5. Addresses 0x10, 0x12 and 0x13 read 0.
- R8: The vector register at address 0x02 resets to 0x0000. It takes a written word at the next edge and drives it on `vec_o`.
- R9: After a module's enabled pending state falls, `irq_o` stays high for 1 more cycle if the module's sources are asynchronous (M0, M4, M5 by default). It stays high for 2 more cycles if they are synchronous (M1, M2, M3).
- R10: Clearing the global enable drops `irq_o` at the very next edge, with no extra hold cycle.
- R11: A flag that is not cleared stays set, and it keeps `irq_o` high for as long as its enables are set.
- R12: Writes to read-only addresses (0x03, 0x10 to 0x15) change nothing. Unmapped addresses 0x16 to 0x1F read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 96 | Event pulses, bit m*16+s is source s of module m |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Request to the processor |
| vec_o | output | 16 | Interrupt vector |

## Verification
Flags, enables and the vector are registered. Each of them is due one edge after the event or write that changes it. The identity registers follow combinationally from those registers, so they are read in the same sample slot just after that edge. `irq_o` rises one edge after an event. After a clearing write it stays high for one further edge on asynchronous modules and two on synchronous ones. The bench therefore changes inputs on the falling edge and samples 1 ns after each rising edge. It steps exactly one edge between drop checks, so every module's hold length is measured to the cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_MOD = 6;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;

  // Register map; the per-module groups are indexed by module number.
  localparam logic [ADDR_W-1:0] A_GCTL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_MODEN = 5'h01;
  localparam logic [ADDR_W-1:0] A_VEC   = 5'h02;
  localparam logic [ADDR_W-1:0] A_TOPID = 5'h03;
  localparam logic [ADDR_W-1:0] A_FLAG0 = 5'h04;
  localparam logic [ADDR_W-1:0] A_SEN0  = 5'h0A;
  localparam logic [ADDR_W-1:0] A_MID0  = 5'h10;

  function automatic logic [ADDR_W-1:0] mod_addr(logic [ADDR_W-1:0] base, int m);
    return base + ADDR_W'(m);
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic                            glb_en,
  output logic [NUM_MOD-1:0]              mod_en,
  output logic [DATA_W-1:0]               vec,
  output logic [NUM_MOD-1:0][SRC_W-1:0]   src_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      mod_en <= '0;
      vec    <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_GCTL)  glb_en <= wr_data[0];
      if (wr_addr == A_MODEN) mod_en <= wr_data[NUM_MOD-1:0];
      if (wr_addr == A_VEC)   vec    <= wr_data;
    end
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_sen
    always_ff @(posedge clk) begin
      if (!rst_n) src_en[m] <= '0;
      else if (wr_en && wr_addr == mod_addr(A_SEN0, m))
        src_en[m] <= wr_data[SRC_W-1:0];
    end
  end

  // R8: vector write lands on the next edge
  assert_vec_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_VEC) |=> (vec == $past(wr_data)));
endmodule

// File: rtl/intc_flags.sv
module intc_flags
  import intc_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_MOD-1:0][SRC_W-1:0]   evt,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_MOD-1:0][SRC_W-1:0]   flag
);
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic [SRC_W-1:0] clr;
    assign clr = (wr_en && wr_addr == mod_addr(A_FLAG0, m)) ? wr_data[SRC_W-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) flag[m] <= '0;
      else        flag[m] <= (flag[m] & ~clr) | evt[m];
    end

    // R2: an event always latches
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[m] != '0) |=> ((flag[m] & $past(evt[m])) == $past(evt[m])));
    // R3: cleared bits without a new event go low
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~evt[m]) != '0) |=> ((flag[m] & $past(clr & ~evt[m])) == '0));
    // R4: event beats clear
    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & evt[m]) != '0) |=> ((flag[m] & $past(clr & evt[m])) == $past(clr & evt[m])));
    // R11: untouched bits hold
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr | evt[m]) == '0) |=> (flag[m] == $past(flag[m])));
  end
endmodule

// File: rtl/intc_drop.sv
module intc_drop #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  output logic req
);
  logic [DEPTH-1:0] hist;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (!rst_n) hist <= '0;
      else        hist <= live;
    end
    // R9: released one cycle after the fall
    assert_drop_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !$past(live)) |-> !req);
  end else begin : g_multi
    always_ff @(posedge clk) begin
      if (!rst_n) hist <= '0;
      else        hist <= {hist[DEPTH-2:0], live};
    end
    // R9: released two cycles after the fall
    assert_drop_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !$past(live) && !$past(live, 2)) |-> !req);
  end

  assign req = live | (|hist);

  // R9: request still held in the first cycle after the fall
  assert_drop_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(live) |-> req);
endmodule

// File: rtl/intc_hier.sv
module intc_hier
  import intc_pkg::*;
#(
  parameter int                 SRC_W     = 16,
  parameter logic [NUM_MOD-1:0] ID_MASK   = 6'b110010,
  parameter logic [NUM_MOD-1:0] SYNC_MASK = 6'b001110
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_MOD*SRC_W-1:0]    evt_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        irq_o,
  output logic [DATA_W-1:0]           vec_o
);
  logic                           glb_en;
  logic [NUM_MOD-1:0]             mod_en;
  logic [NUM_MOD-1:0][SRC_W-1:0]  src_en;
  logic [NUM_MOD-1:0][SRC_W-1:0]  evt;
  logic [NUM_MOD-1:0][SRC_W-1:0]  flag;
  logic [NUM_MOD-1:0][SRC_W-1:0]  hit;
  logic [NUM_MOD-1:0]             top_id;
  logic [NUM_MOD-1:0]             mod_req;

  assign evt = evt_i;

  intc_regs #(.SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .glb_en(glb_en), .mod_en(mod_en), .vec(vec_o),
    .src_en(src_en)
  );

  intc_flags #(.SRC_W(SRC_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en_i),
    .wr_addr(wr_addr_i), .wr_data(wr_data_i), .flag(flag)
  );

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    assign hit[m]    = flag[m] & src_en[m];
    assign top_id[m] = mod_en[m] & (|hit[m]);
    intc_drop #(.DEPTH(SYNC_MASK[m] ? 2 : 1)) u_drop (
      .clk(clk), .rst_n(rst_n), .live(top_id[m]), .req(mod_req[m])
    );
  end

  assign irq_o = glb_en & (|mod_req);

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_GCTL)  rd_data_o = DATA_W'(glb_en);
    if (rd_addr_i == A_MODEN) rd_data_o = DATA_W'(mod_en);
    if (rd_addr_i == A_VEC)   rd_data_o = vec_o;
    if (rd_addr_i == A_TOPID) rd_data_o = DATA_W'(top_id);
    for (int m = 0; m < NUM_MOD; m++) begin
      if (rd_addr_i == mod_addr(A_FLAG0, m)) rd_data_o = DATA_W'(flag[m]);
      if (rd_addr_i == mod_addr(A_SEN0, m))  rd_data_o = DATA_W'(src_en[m]);
      if (ID_MASK[m] && rd_addr_i == mod_addr(A_MID0, m)) rd_data_o = DATA_W'(hit[m]);
    end
  end

  // R10: no request while globally disabled
  assert_glb_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_o);
  // R5: any enabled pending module with the global enable raises the request
  assert_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && top_id != '0) |-> irq_o);
  // R6: a module shown pending always has its request up
  assert_topid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((top_id & ~mod_req) == '0));
endmodule

// File: tb/sim_intc_hier.sv
`timescale 1ns/1ps
module sim_intc_hier;
  import intc_pkg::*;
  localparam int SW = 16;
  localparam int EW = NUM_MOD*SW;
  localparam logic [NUM_MOD-1:0] IDM = 6'b110010;
  localparam logic [NUM_MOD-1:0] SYM = 6'b001110;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [EW-1:0] evt = '0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data, vec;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intc_hier u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  task automatic chk_rd(string req, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic wr_evt(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic w, input logic [EW-1:0] e);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; evt = e;
    @(posedge clk); #1;
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_evt(a, d, 1'b1, '0);
  endtask

  task automatic pulse(input logic [EW-1:0] e);
    wr_evt(5'h00, '0, 1'b0, e);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 vec", vec, 0);
    for (int a = 0; a < 32; a++) chk_rd("R1 regs", ADDR_W'(a), 16'h0000);

    // R8 vector register
    wr(A_VEC, 16'hBEEF);
    chk("R8 vec_o", vec, 16'hBEEF);
    chk_rd("R8 read", A_VEC, 16'hBEEF);
    wr(A_VEC, 16'h1234);
    chk("R8 vec_o", vec, 16'h1234);

    // R2 flags latch with every enable off
    pulse('1);
    chk("R2 irq low", irq, 0);
    for (int m = 0; m < NUM_MOD; m++) chk_rd("R2 flag", A_FLAG0 + ADDR_W'(m), 16'hFFFF);
    chk_rd("R2 topid", A_TOPID, 0);
    for (int m = 0; m < NUM_MOD; m++) wr(A_FLAG0 + ADDR_W'(m), 16'hFFFF);
    for (int m = 0; m < NUM_MOD; m++) chk_rd("R3 cleared", A_FLAG0 + ADDR_W'(m), 16'h0000);

    // enable everything
    for (int m = 0; m < NUM_MOD; m++) wr(A_SEN0 + ADDR_W'(m), 16'hFFFF);
    wr(A_MODEN, 16'h003F);
    wr(A_GCTL, 16'h0001);

    // sweep over every source: R5, R6, R7, R9
    for (int m = 0; m < NUM_MOD; m++) begin
      for (int s = 0; s < SW; s++) begin
        logic [EW-1:0] e;
        logic [DATA_W-1:0] bitv;
        e = '0; e[m*SW+s] = 1'b1;
        bitv = 16'(1) << s;
        chk("R5 idle", irq, 0);
        pulse(e);
        chk("R5 irq up", irq, 1);
        chk_rd("R6 topid", A_TOPID, 16'(1) << m);
        chk_rd("R7 modid", A_MID0 + ADDR_W'(m), IDM[m] ? bitv : 16'h0000);
        chk_rd("R2 flag", A_FLAG0 + ADDR_W'(m), bitv);
        wr(A_FLAG0 + ADDR_W'(m), bitv);
        chk("R9 hold 1", irq, 1);
        step();
        chk("R9 hold 2", irq, SYM[m] ? 1 : 0);
        step();
        chk("R9 released", irq, 0);
      end
    end

    // R3 partial clear, R7 on module 4
    pulse(EW'(16'hF0F0) << (4*SW));
    wr(A_FLAG0 + 5'd4, 16'h00FF);
    chk_rd("R3 partial", A_FLAG0 + 5'd4, 16'hF000);
    chk_rd("R7 M4 id", A_MID0 + 5'd4, 16'hF000);

    // R4 event beats clear
    wr_evt(A_FLAG0, 16'h0008, 1'b1, EW'(16'h0008));
    chk_rd("R4 evt wins", A_FLAG0, 16'h0008);
    chk_rd("R7 M0 no id", A_MID0, 16'h0000);

    // R6 module enable gating
    wr(A_MODEN, 16'h0001);
    chk_rd("R6 topid masked", A_TOPID, 16'h0001);
    chk("R6 irq", irq, 1);
    wr(A_MODEN, 16'h003F);
    chk_rd("R6 topid both", A_TOPID, 16'h0011);

    // R11 persistence
    repeat (5) step();
    chk("R11 irq held", irq, 1);
    chk_rd("R11 flag held", A_FLAG0 + 5'd4, 16'hF000);

    // R10 global disable takes effect at once
    wr(A_GCTL, 16'h0000);
    chk("R10 irq off", irq, 0);
    chk_rd("R10 topid kept", A_TOPID, 16'h0011);
    wr(A_GCTL, 16'h0001);
    chk("R10 irq back", irq, 1);

    // R12 read-only and unmapped addresses
    wr(A_TOPID, 16'hFFFF);
    chk_rd("R12 topid ro", A_TOPID, 16'h0011);
    wr(A_MID0 + 5'd4, 16'h0000);
    chk_rd("R12 modid ro", A_MID0 + 5'd4, 16'hF000);
    chk_rd("R12 flags kept", A_FLAG0 + 5'd4, 16'hF000);
    for (int a = 16'h16; a < 32; a++) chk_rd("R12 unmapped", ADDR_W'(a), 16'h0000);

    // R7 source enable masks the module identity
    wr(A_SEN0 + 5'd4, 16'h0FFF);
    chk_rd("R7 masked id", A_MID0 + 5'd4, 16'h0000);
    chk_rd("R6 topid src masked", A_TOPID, 16'h0001);

    finish_run();
  end
endmodule